// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End

This block sits between a host processor and the core of a display controller. It accepts byte transfers either over an 8-bit parallel bus or over a write-only two-wire serial link, picked by a static path-select pin. On the parallel path a second static pin picks between a bus with one enable strobe and a read/write level (68-style) and a bus with separate active-low read and write strobes (80-style). A two-signal chip select (one active-low, one active-high) gates all activity.

Every host-side input is brought into the system clock domain through two-flop synchronizers. Edge detectors then find the end of each write and the start of each read. Each completed access leaves the block as one single-cycle pulse. The pulse carries an access kind and, for writes, the byte. The core returns a read byte, and the block places it on the bus output while a selected read is in progress. For a status read the block returns the busy flag instead. The system clock must run at least four times faster than the serial clock, and host strobes must hold each level for at least two system clocks.

Top module: `hostbus_front`

## Requirements
- R1: A transfer is accepted only while `cs1_n` is 0 and `cs2` is 1 together. Otherwise strobes and serial clocks produce no pulse, and `bus_oe` stays 0.
- R2: In 80-style parallel mode (`par_mode`=1, `m68_mode`=0), a 0-to-1 transition of `wr_rw` ends a write. The block then issues one pulse carrying the byte that was on `bus_in` and the kind set by `a0`.
- R3: In 80-style mode, `bus_oe` is 1 while `rd_e` is 0 and the block is selected. When `a0`=1 the bus returns `rd_byte`.
- R4: A read with `a0`=0 is a status read. It returns `busy` in bit 7 and zeros in bits 6..0.
- R5: In 68-style mode (`m68_mode`=1), `rd_e` is an active-high enable and `wr_rw`=1 means read. `bus_oe` is 1 while enable and read are both high. A 1-to-0 transition of the enable with `wr_rw`=0 ends a write.
- R6: The start of each selected parallel read issues one pulse with kind 10 (display read, `a0`=1) or 11 (status read, `a0`=0), and `xfer_byte` = 0.
- R7: In serial mode (`par_mode`=0), `bus_in[7]` is data and `bus_in[6]` is the clock. Bits are shifted in most significant bit first on rising clock edges, and the byte is issued after the eighth rising edge.
- R8: In serial mode, `a0` is sampled only at the eighth rising edge of each byte. Its value at the other seven edges has no effect.
- R9: Deselecting the block in serial mode clears the bit counter and the shift register. A partly shifted byte is therefore discarded.
- R10: In serial mode reads are not possible: `bus_oe` stays 0, and the parallel strobes produce no pulse.
- R11: `xfer_kind` encodes the access as {read, command}: 00 display-data write, 01 command write, 10 display-data read, 11 status read. `xfer_valid` is high for exactly one cycle per completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| par_mode | input | 1 | Static path select: 1 = parallel, 0 = serial |
| m68_mode | input | 1 | Static bus style: 1 = 68-style, 0 = 80-style |
| a0 | input | 1 | 1 = display data, 0 = command/status |
| rd_e | input | 1 | 80-style read strobe (active low) or 68-style enable (active high) |
| wr_rw | input | 1 | 80-style write strobe (active low) or 68-style read/write level |
| bus_in | input | 8 | Host data bus in; serial data on bit 7 and serial clock on bit 6 |
| bus_out | output | 8 | Byte driven toward the host during reads |
| bus_oe | output | 1 | Output enable for the host data bus |
| rd_byte | input | 8 | Display byte returned by the core |
| busy | input | 1 | Core busy flag for status reads |
| xfer_valid | output | 1 | One-cycle pulse per completed access |
| xfer_kind | output | 2 | Access kind, encoded as in R11 |
| xfer_byte | output | 8 | Written byte (0 for reads) |

## Verification
The bench targets three serial cases. Setting `a0` to one value on the first seven bits and the opposite value on the eighth catches a design that samples the flag early, which would report the wrong kind. Breaking off a byte with a deselect and then sending a full byte catches a design that keeps its bit count, which would issue a shifted or early byte. Two bytes sent back to back check that the counter wraps cleanly.

On the parallel side, strobes are toggled under each half of the chip select alone, and this must yield neither a pulse nor an output enable. Both bus styles are exercised for every access kind, which catches a swapped strobe polarity or a write taken at the wrong edge. Status reads are run with the busy flag both set and clear, and read strobes are driven in serial mode, where a leaking output enable would be a bus fight.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  // access kind, encoded {read, command}
  localparam logic [1:0] KIND_DATA_WR = 2'b00;
  localparam logic [1:0] KIND_CMD_WR  = 2'b01;
  localparam logic [1:0] KIND_DATA_RD = 2'b10;
  localparam logic [1:0] KIND_STAT_RD = 2'b11;

  function automatic logic [1:0] make_kind(input logic is_read, input logic a0_lvl);
    return {is_read, ~a0_lvl};
  endfunction
endpackage

// File: rtl/hbf_sync.sv
// Multi-stage synchronizer with one extra history stage for edge detection.
module hbf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [STAGES:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], d};
  end

  assign q   = chain[STAGES-1];
  assign q_d = chain[STAGES];
endmodule

// File: rtl/hbf_par.sv
// Parallel strobe decoder for both bus styles (combinational, synced inputs).
module hbf_par (
  input  logic en,
  input  logic is_68,
  input  logic cs_now,
  input  logic cs_prev,
  input  logic strb_a,
  input  logic strb_a_d,
  input  logic strb_b,
  input  logic strb_b_d,
  output logic ev_wr,
  output logic ev_rd,
  output logic rd_active
);
  logic held_sel, rd_now, rd_prev, wr_end;

  always_comb begin
    held_sel = en & cs_now & cs_prev;
    if (is_68) begin
      rd_now  = strb_a & strb_b;
      rd_prev = strb_a_d & strb_b_d;
      wr_end  = ~strb_a & strb_a_d & ~strb_b_d;
    end else begin
      rd_now  = ~strb_a;
      rd_prev = ~strb_a_d;
      wr_end  = strb_b & ~strb_b_d;
    end
    ev_wr     = held_sel & wr_end;
    ev_rd     = held_sel & rd_now & ~rd_prev;
    rd_active = en & cs_now & rd_now;
  end
endmodule

// File: rtl/hbf_ser.sv
// Serial receiver: MSB first, byte and flag taken on the last clock of a byte.
module hbf_ser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cs,
  input  logic              sck,
  input  logic              sck_d,
  input  logic              sdi,
  input  logic              flag,
  output logic              ev,
  output logic [DATA_W-1:0] byte_o,
  output logic              flag_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              rise;

  always_comb begin
    rise   = en & cs & sck & ~sck_d;
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    ev     = 1'b0;
    byte_o = {sh_q[DATA_W-2:0], sdi};
    flag_o = flag;
    if (!en || !cs) begin
      sh_n  = '0;
      cnt_n = '0;
    end else if (rise) begin
      sh_n  = {sh_q[DATA_W-2:0], sdi};
      cnt_n = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      ev    = (cnt_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/hostbus_front.sv
module hostbus_front #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SDI_BIT     = 7,
  parameter int SCK_BIT     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              par_mode,
  input  logic              m68_mode,
  input  logic              a0,
  input  logic              rd_e,
  input  logic              wr_rw,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] rd_byte,
  input  logic              busy,
  output logic              xfer_valid,
  output logic [1:0]        xfer_kind,
  output logic [DATA_W-1:0] xfer_byte
);
  import hbf_pkg::*;

  localparam int SW = DATA_W + 4;

  logic [SW-1:0]     raw, s, s_d;
  logic              cs_s, cs_sd, a0_s, ra_s, ra_sd, wb_s, wb_sd;
  logic [DATA_W-1:0] bus_s;
  logic              p_wr, p_rd, p_oe;
  logic              s_ev, s_flag;
  logic [DATA_W-1:0] s_byte;
  logic              v_n;
  logic [1:0]        k_n;
  logic [DATA_W-1:0] b_n;

  assign raw = {~cs1_n & cs2, a0, rd_e, wr_rw, bus_in};

  hbf_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(s), .q_d(s_d)
  );

  assign {cs_s, a0_s, ra_s, wb_s, bus_s} = s;
  assign cs_sd = s_d[SW-1];
  assign ra_sd = s_d[DATA_W+1];
  assign wb_sd = s_d[DATA_W];

  hbf_par u_par (
    .en(par_mode), .is_68(m68_mode), .cs_now(cs_s), .cs_prev(cs_sd),
    .strb_a(ra_s), .strb_a_d(ra_sd), .strb_b(wb_s), .strb_b_d(wb_sd),
    .ev_wr(p_wr), .ev_rd(p_rd), .rd_active(p_oe)
  );

  hbf_ser #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .en(~par_mode), .cs(cs_s),
    .sck(bus_s[SCK_BIT]), .sck_d(s_d[SCK_BIT]), .sdi(bus_s[SDI_BIT]),
    .flag(a0_s), .ev(s_ev), .byte_o(s_byte), .flag_o(s_flag)
  );

  // next-state for the output pulse register
  always_comb begin
    v_n = 1'b0;
    k_n = KIND_DATA_WR;
    b_n = '0;
    if (par_mode) begin
      if (p_wr) begin
        v_n = 1'b1;
        k_n = make_kind(1'b0, a0_s);
        b_n = bus_s;
      end else if (p_rd) begin
        v_n = 1'b1;
        k_n = make_kind(1'b1, a0_s);
      end
    end else if (s_ev) begin
      v_n = 1'b1;
      k_n = make_kind(1'b0, s_flag);
      b_n = s_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_valid <= 1'b0;
      xfer_kind  <= KIND_DATA_WR;
      xfer_byte  <= '0;
    end else begin
      xfer_valid <= v_n;
      if (v_n) begin
        xfer_kind <= k_n;
        xfer_byte <= b_n;
      end
    end
  end

  assign bus_oe  = p_oe;
  assign bus_out = !p_oe ? '0 :
                   a0_s  ? rd_byte : {busy, {(DATA_W-1){1'b0}}};
endmodule

// File: rtl/hostbus_front_chk.sv
module hostbus_front_chk (
  input logic clk,
  input logic rst_n,
  input logic cs1_n,
  input logic cs2,
  input logic par_mode,
  input logic m68_mode,
  input logic rd_e,
  input logic bus_oe,
  input logic xfer_valid
);
  // R1
  oe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(!cs1_n && cs2, 2));

  // R1
  pulse_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> $past(!cs1_n && cs2, 3));

  // R3
  oe80_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && par_mode && !m68_mode) |-> $past(!rd_e, 2));

  // R10
  serial_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_mode |-> !bus_oe);

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> !xfer_valid);
endmodule

bind hostbus_front hostbus_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .par_mode(par_mode),
  .m68_mode(m68_mode), .rd_e(rd_e), .bus_oe(bus_oe), .xfer_valid(xfer_valid)
);

// File: tb/tb_hostbus_front.sv
`timescale 1ns/1ps
module tb_hostbus_front;
  logic clk = 1'b0;
  logic rst_n;
  logic cs1_n, cs2, par_mode, m68_mode, a0, rd_e, wr_rw, busy;
  logic [7:0] bus_in, rd_byte, bus_out, xfer_byte;
  logic bus_oe, xfer_valid;
  logic [1:0] xfer_kind;

  int n_tests = 0;
  int n_fail  = 0;
  int pulses  = 0;
  int run_len = 0;
  int max_run = 0;
  logic [1:0] last_kind;
  logic [7:0] last_byte;

  always #10 clk = ~clk;

  hostbus_front dut (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .par_mode(par_mode),
    .m68_mode(m68_mode), .a0(a0), .rd_e(rd_e), .wr_rw(wr_rw), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .rd_byte(rd_byte), .busy(busy),
    .xfer_valid(xfer_valid), .xfer_kind(xfer_kind), .xfer_byte(xfer_byte)
  );

  always @(posedge clk) begin
    if (xfer_valid) begin
      pulses    <= pulses + 1;
      last_kind <= xfer_kind;
      last_byte <= xfer_byte;
      run_len    = run_len + 1;
      if (run_len > max_run) max_run = run_len;
    end else begin
      run_len = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_par(input logic m68);
    cs1_n = 1'b1; cs2 = 1'b1; cyc(2);
    par_mode = 1'b1; m68_mode = m68;
    rd_e = m68 ? 1'b0 : 1'b1; wr_rw = 1'b1;
    cyc(6);
    cs1_n = 1'b0; cyc(6);
  endtask

  task automatic t_reset;
    check("R11 reset valid", int'(xfer_valid), 0);
    check("R1 reset oe", int'(bus_oe), 0);
  endtask

  task automatic t_80_write;
    int p0;
    idle_par(1'b0);
    p0 = pulses;
    a0 = 1'b0; bus_in = 8'h6D; wr_rw = 1'b0; cyc(3);
    wr_rw = 1'b1; cyc(3); bus_in = 8'h00; cyc(5);
    check("R2 cmd write count", pulses - p0, 1);
    check("R2 cmd write kind", int'(last_kind), 1);
    check("R2 cmd write byte", int'(last_byte), 8'h6D);
    a0 = 1'b1; bus_in = 8'hB2; wr_rw = 1'b0; cyc(3);
    wr_rw = 1'b1; cyc(3); cyc(5);
    check("R2 data write kind", int'(last_kind), 0);
    check("R2 data write byte", int'(last_byte), 8'hB2);
  endtask

  task automatic t_80_read;
    int p0;
    p0 = pulses;
    a0 = 1'b1; rd_byte = 8'h3C; rd_e = 1'b0; cyc(5);
    check("R3 read oe", int'(bus_oe), 1);
    check("R3 read data", int'(bus_out), 8'h3C);
    rd_e = 1'b1; cyc(5);
    check("R3 oe released", int'(bus_oe), 0);
    check("R6 display read pulse", pulses - p0, 1);
    check("R6 display read kind", int'(last_kind), 2);
    check("R6 read byte zero", int'(last_byte), 0);
  endtask

  task automatic t_status;
    a0 = 1'b0; busy = 1'b1; rd_e = 1'b0; cyc(5);
    check("R4 status busy set", int'(bus_out), 8'h80);
    busy = 1'b0; cyc(1);
    check("R4 status busy clear", int'(bus_out), 8'h00);
    rd_e = 1'b1; cyc(5);
    check("R6 status kind", int'(last_kind), 3);
  endtask

  task automatic t_deselect;
    int p0;
    p0 = pulses;
    cs1_n = 1'b1; cyc(4);
    wr_rw = 1'b0; cyc(3); wr_rw = 1'b1; cyc(3);
    rd_e = 1'b0; cyc(4);
    check("R1 cs1 high no oe", int'(bus_oe), 0);
    rd_e = 1'b1; cyc(5);
    check("R1 cs1 high no pulse", pulses - p0, 0);
    cs1_n = 1'b0; cs2 = 1'b0; cyc(4);
    wr_rw = 1'b0; cyc(3); wr_rw = 1'b1; cyc(3);
    rd_e = 1'b0; cyc(4);
    check("R1 cs2 low no oe", int'(bus_oe), 0);
    rd_e = 1'b1; cyc(5);
    check("R1 cs2 low no pulse", pulses - p0, 0);
    cs2 = 1'b1; cyc(4);
  endtask

  task automatic t_68;
    int p0;
    idle_par(1'b1);
    p0 = pulses;
    a0 = 1'b0; bus_in = 8'h91; wr_rw = 1'b0; cyc(2);
    rd_e = 1'b1; cyc(3); rd_e = 1'b0; cyc(3); wr_rw = 1'b1; cyc(5);
    check("R5 68 write count", pulses - p0, 1);
    check("R5 68 write kind", int'(last_kind), 1);
    check("R5 68 write byte", int'(last_byte), 8'h91);
    check("R5 68 idle oe", int'(bus_oe), 0);
    a0 = 1'b1; rd_byte = 8'h4E; rd_e = 1'b1; cyc(5);
    check("R5 68 read oe", int'(bus_oe), 1);
    check("R5 68 read data", int'(bus_out), 8'h4E);
    rd_e = 1'b0; cyc(5);
    check("R6 68 read kind", int'(last_kind), 2);
    check("R5 68 total pulses", pulses - p0, 2);
  endtask

  task automatic ser_bit(input logic b, input logic flag);
    bus_in[7] = b; a0 = flag; cyc(5);
    bus_in[6] = 1'b1; cyc(5);
    bus_in[6] = 1'b0;
  endtask

  task automatic ser_byte(input logic [7:0] v, input logic [7:0] flags);
    for (int i = 7; i >= 0; i--) ser_bit(v[i], flags[i]);
  endtask

  task automatic enter_serial;
    cs1_n = 1'b1; cyc(2);
    par_mode = 1'b0; m68_mode = 1'b0; rd_e = 1'b1; wr_rw = 1'b1;
    bus_in = 8'h00; cyc(6);
    cs1_n = 1'b0; cyc(6);
  endtask

  task automatic t_serial_basic;
    int p0;
    enter_serial();
    p0 = pulses;
    ser_byte(8'hA5, 8'hFF); cyc(6);
    check("R7 serial count", pulses - p0, 1);
    check("R7 serial byte", int'(last_byte), 8'hA5);
    check("R7 serial kind", int'(last_kind), 0);
  endtask

  task automatic t_serial_flag;
    ser_byte(8'h3C, 8'h01); cyc(6);
    check("R8 late a0 high kind", int'(last_kind), 0);
    check("R8 byte", int'(last_byte), 8'h3C);
    ser_byte(8'hC3, 8'hFE); cyc(6);
    check("R8 late a0 low kind", int'(last_kind), 1);
  endtask

  task automatic t_serial_abort;
    int p0;
    p0 = pulses;
    ser_bit(1'b1, 1'b1); ser_bit(1'b1, 1'b1); ser_bit(1'b0, 1'b1);
    cs1_n = 1'b1; cyc(6); cs1_n = 1'b0; cyc(6);
    ser_byte(8'h5A, 8'hFF); cyc(6);
    check("R9 abort count", pulses - p0, 1);
    check("R9 abort byte", int'(last_byte), 8'h5A);
  endtask

  task automatic t_serial_b2b;
    int p0;
    p0 = pulses;
    ser_byte(8'h81, 8'hFF); ser_byte(8'h7E, 8'h00); cyc(6);
    check("R7 back to back count", pulses - p0, 2);
    check("R7 second byte", int'(last_byte), 8'h7E);
    check("R11 second kind cmd", int'(last_kind), 1);
  endtask

  task automatic t_serial_noread;
    int p0;
    p0 = pulses;
    rd_e = 1'b0; cyc(5);
    check("R10 serial oe", int'(bus_oe), 0);
    rd_e = 1'b1; wr_rw = 1'b0; cyc(3); wr_rw = 1'b1; cyc(5);
    check("R10 serial strobes no pulse", pulses - p0, 0);
  endtask

  initial begin : watchdog
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs1_n = 1'b1; cs2 = 1'b0; par_mode = 1'b1; m68_mode = 1'b0;
    a0 = 1'b0; rd_e = 1'b1; wr_rw = 1'b1; bus_in = 8'h00; rd_byte = 8'h00;
    busy = 1'b0;
    cyc(4);
    t_reset();
    rst_n = 1'b1; cyc(4);
    t_reset();
    t_80_write();
    t_80_read();
    t_status();
    t_deselect();
    t_68();
    t_serial_basic();
    t_serial_flag();
    t_serial_abort();
    t_serial_b2b();
    t_serial_noread();
    check("R11 pulse width", max_run, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule